// File: doc/BRIEF.md
# Masked Control Register File

The block holds the internal control registers of a processor core. Each register is 64 bits wide. Registers are selected by a 6-bit index through one read port and one write port. Every index has its own write rule:

- a plain 64-bit store;
- a store through a fixed bit mask;
- a sticky register that hardware sets and any software write clears;
- a read-only view of hardware state;
- a write-only command.

An access that breaks the rule for its index raises a fault flag for an unimplemented operation.

A free-running cycle counter runs inside the block. It supplies the low bits of the cycle register whenever that register is read. Commands that maintain the translation buffers and caches are not carried out here. They leave the block as one-hot strobes together with the write data, for the neighbouring units to act on.

Reads are registered, and the result arrives one cycle after the request. Writes take effect at the clock edge that samples them. The write fault flag and the command strobes appear in the same cycle as the state update.

Top module: `ctl_regfile`

## Requirements
- R1: After reset every stored register reads zero, except index 8 (the privileged base), which reads the parameter BASE_RST. rd_valid, wr_fault and op_strobe are all low until an access occurs.
- R2: A read presented at a clock edge returns rd_data, rd_fault and rd_valid=1 after that edge. A read of an index that is written at the same edge returns the value held before the write.
- R3: Indices 0 to 7 (scratch), 8 (base), 21 (cycle register upper half) and 22 (page-table-entry staging) store all 64 written bits.
- R4: Indices 9 and 10 (asynchronous-trap enable and request) keep only bits 3:0. Index 11 (priority level) keeps only bits 4:0.
- R5: Indices 12 and 13 (current and alternate mode) keep only bits 4:3. Index 14 (software interrupt request) keeps only the bits of mask 0x7fff0.
- R6: Indices 15 and 16 (data-cache mode and miss-queue mode) keep bits 5:0. Index 17 (instruction TLB ASN) keeps mask 0x7f0. Index 18 (data TLB ASN) keeps bits 63:57.
- R7: Indices 19 and 20 (instruction and data page-table base) keep only bits 63:30.
- R8: Index 23 (exception summary) ORs in exc_sum_set every cycle, and index 24 (exception mask) ORs in exc_mask_set. A write of any data clears the register. Set bits that arrive in the same cycle as the clearing write survive it.
- R9: Index 25 reads int_id_in zero-extended, and index 26 reads mm_stat_in. Writing either index raises wr_fault.
- R10: Indices 32 to 41 are write-only commands. A write to index 32+k raises op_strobe bit k for exactly one cycle, with op_data equal to the written data. Reading any of these indices raises rd_fault and returns zero.
- R11: Reading index 21 returns the stored bits 63:32 above the low 32 bits of a counter that advances once per clock. Two reads N cycles apart therefore differ by N in their low half.
- R12: Any other index (27 to 31, 42 to 63) raises rd_fault and returns zero on read, and raises wr_fault on write.
- R13: wr_fault is low after a write to a writable index, and rd_fault is low after a read of a readable index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| exc_sum_set | input | 64 | Bits to set in the exception summary register |
| exc_mask_set | input | 64 | Bits to set in the exception mask register |
| int_id_in | input | 5 | Current interrupt identifier, read-only view |
| mm_stat_in | input | 64 | Memory-management status, read-only view |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result, zero on a fault |
| rd_fault | output | 1 | Illegal read |
| wr_fault | output | 1 | Illegal write |
| op_strobe | output | 10 | One-hot command strobe |
| op_data | output | 64 | Data that accompanies the command strobe |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it: read data and read fault, write fault, command strobes, and the effect of a write or a set pulse on later reads. The bench drives each request on a falling edge and removes it on the next falling edge. It samples the outputs at that second falling edge, which is half a cycle after the edge that registered them. The counter test spaces its two reads by a known number of edges and compares the difference in the low half against that spacing. The one-cycle length of a command strobe is checked one falling edge later.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

  localparam int IDX_W       = 6;
  localparam int DW          = 64;
  localparam int SLOT_W      = 5;
  localparam int NUM_SLOTS   = 1 << SLOT_W;
  localparam int NUM_SCRATCH = 8;
  localparam int OP_BASE     = 32;
  localparam int NUM_OPS     = 10;
  localparam int OP_W        = $clog2(NUM_OPS);

  localparam int IDX_BASE     = 8;
  localparam int IDX_TRAP_ENA = 9;
  localparam int IDX_TRAP_REQ = 10;
  localparam int IDX_PRIO     = 11;
  localparam int IDX_CUR_MODE = 12;
  localparam int IDX_ALT_MODE = 13;
  localparam int IDX_SOFT_REQ = 14;
  localparam int IDX_DC_MODE  = 15;
  localparam int IDX_MQ_MODE  = 16;
  localparam int IDX_ITB_ASN  = 17;
  localparam int IDX_DTB_ASN  = 18;
  localparam int IDX_IPT_BASE = 19;
  localparam int IDX_DPT_BASE = 20;
  localparam int IDX_CYCLE    = 21;
  localparam int IDX_PTE_STG  = 22;
  localparam int IDX_EXC_SUM  = 23;
  localparam int IDX_EXC_MASK = 24;
  localparam int IDX_INT_ID   = 25;
  localparam int IDX_MM_STAT  = 26;

  typedef enum logic [2:0] {
    K_NONE,
    K_RW,
    K_CLR,
    K_RO,
    K_WO
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input int unsigned i);
    if (i < NUM_SCRATCH)                          return K_RW;
    if (i >= IDX_BASE && i <= IDX_PTE_STG)        return K_RW;
    if (i == IDX_EXC_SUM || i == IDX_EXC_MASK)    return K_CLR;
    if (i == IDX_INT_ID || i == IDX_MM_STAT)      return K_RO;
    if (i >= OP_BASE && i < OP_BASE + NUM_OPS)    return K_WO;
    return K_NONE;
  endfunction

  function automatic logic [DW-1:0] wmask_of(input int unsigned i);
    case (i)
      IDX_TRAP_ENA, IDX_TRAP_REQ: return 64'h0000_0000_0000_000f;
      IDX_PRIO:                   return 64'h0000_0000_0000_001f;
      IDX_CUR_MODE, IDX_ALT_MODE: return 64'h0000_0000_0000_0018;
      IDX_SOFT_REQ:               return 64'h0000_0000_0007_fff0;
      IDX_DC_MODE, IDX_MQ_MODE:   return 64'h0000_0000_0000_003f;
      IDX_ITB_ASN:                return 64'h0000_0000_0000_07f0;
      IDX_DTB_ASN:                return 64'hfe00_0000_0000_0000;
      IDX_IPT_BASE, IDX_DPT_BASE: return 64'hffff_ffff_c000_0000;
      default:                    return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge_live(input logic [DW-1:0] stored,
                                               input logic [DW-1:0] live,
                                               input logic [DW-1:0] live_mask);
    return (stored & ~live_mask) | (live & live_mask);
  endfunction

endpackage

// File: rtl/ctl_regfile_decode.sv
module ctl_regfile_decode
  import ctl_regfile_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind
);
  assign kind = kind_of(int'(idx));
endmodule

// File: rtl/ctl_regfile_counter.sv
module ctl_regfile_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + 1'b1); // R11
endmodule

// File: rtl/ctl_regfile_opstrobe.sv
module ctl_regfile_opstrobe #(
  parameter int NOPS  = 10,
  parameter int SEL_W = 4,
  parameter int DWID  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [SEL_W-1:0] sel,
  input  logic [DWID-1:0] data,
  output logic [NOPS-1:0] strobe,
  output logic [DWID-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe <= '0;
      data_q <= '0;
    end else begin
      strobe <= fire ? (NOPS'(1) << sel) : '0;
      if (fire) data_q <= data;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe)); // R10
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) && !fire |=> strobe == '0); // R10
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_regfile_pkg::*;
#(
  parameter logic [63:0] BASE_RST = 64'h0000_0000_0040_0000,
  parameter int          CNT_W    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [5:0]  rd_idx,
  input  logic        wr_en,
  input  logic [5:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [63:0] exc_sum_set,
  input  logic [63:0] exc_mask_set,
  input  logic [4:0]  int_id_in,
  input  logic [63:0] mm_stat_in,
  output logic        rd_valid,
  output logic [63:0] rd_data,
  output logic        rd_fault,
  output logic        wr_fault,
  output logic [9:0]  op_strobe,
  output logic [63:0] op_data
);
  localparam logic [DW-1:0] LIVE_MASK = (CNT_W >= DW) ? '1 : ((DW'(1) << CNT_W) - 1'b1);

  reg_kind_e rd_kind, wr_kind;
  logic [CNT_W-1:0] cyc_cnt;
  logic [DW-1:0] slot_q [NUM_SLOTS];

  ctl_regfile_decode u_rd_dec (.idx(rd_idx), .kind(rd_kind));
  ctl_regfile_decode u_wr_dec (.idx(wr_idx), .kind(wr_kind));

  ctl_regfile_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cyc_cnt)
  );

  // named events for the assertions and the strobe unit
  logic wr_illegal, rd_illegal, op_fire;
  assign wr_illegal = (wr_kind == K_RO) || (wr_kind == K_NONE);
  assign rd_illegal = (rd_kind == K_WO) || (rd_kind == K_NONE);
  assign op_fire    = wr_en && (wr_kind == K_WO);

  ctl_regfile_opstrobe #(.NOPS(NUM_OPS), .SEL_W(OP_W), .DWID(DW)) u_ops (
    .clk(clk), .rst_n(rst_n), .fire(op_fire),
    .sel(OP_W'(wr_idx - IDX_W'(OP_BASE))), .data(wr_data),
    .strobe(op_strobe), .data_q(op_data)
  );

  // storage slots, one variant per write rule
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam reg_kind_e       K     = kind_of(g);
    localparam logic [DW-1:0]   M     = wmask_of(g);
    localparam logic [DW-1:0]   RV    = (g == IDX_BASE) ? BASE_RST : '0;
    localparam logic [IDX_W-1:0] MY_IX = IDX_W'(g);
    logic [DW-1:0] q;
    if (K == K_RW) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)                        q <= RV;
        else if (wr_en && wr_idx == MY_IX) q <= wr_data & M;
      end
    end else if (K == K_CLR) begin : g_clr
      logic [DW-1:0] set_v;
      if (g == IDX_EXC_SUM) begin : g_sum
        assign set_v = exc_sum_set;
      end else begin : g_msk
        assign set_v = exc_mask_set;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((wr_en && wr_idx == MY_IX) ? '0 : q) | set_v;
      end
    end else begin : g_none
      assign q = '0;
    end
    assign slot_q[g] = q;
  end

  // read mux
  logic [DW-1:0] rd_val_c;
  always_comb begin
    rd_val_c = '0;
    case (rd_kind)
      K_RW, K_CLR: begin
        if (int'(rd_idx) == IDX_CYCLE)
          rd_val_c = merge_live(slot_q[IDX_CYCLE], DW'(cyc_cnt), LIVE_MASK);
        else
          rd_val_c = slot_q[rd_idx[SLOT_W-1:0]];
      end
      K_RO: rd_val_c = (int'(rd_idx) == IDX_INT_ID) ? DW'(int_id_in) : mm_stat_in;
      default: rd_val_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_fault <= 1'b0;
      wr_fault <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_val_c : '0;
      rd_fault <= rd_en && rd_illegal;
      wr_fault <= wr_en && wr_illegal;
    end
  end

  AST_FAULT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_fault |-> rd_data == '0); // R12
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) == IDX_EXC_SUM |=> slot_q[IDX_EXC_SUM] == $past(exc_sum_set)); // R8
  AST_RO_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) == IDX_INT_ID |=> wr_fault); // R9
  AST_PRIO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[IDX_PRIO][DW-1:5] == '0); // R4
  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> op_strobe != '0 && !wr_fault); // R10
endmodule

// File: tb/ctl_regfile_bench.sv
`timescale 1ns/1ps
module ctl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0]  rd_idx = '0, wr_idx = '0;
  logic [63:0] wr_data = '0, exc_sum_set = '0, exc_mask_set = '0, mm_stat_in = '0;
  logic [4:0]  int_id_in = '0;
  logic        rd_valid, rd_fault, wr_fault;
  logic [63:0] rd_data, op_data;
  logic [9:0]  op_strobe;

  localparam logic [63:0] BASE_V = 64'h0000_0000_0040_0000;

  ctl_regfile #(.BASE_RST(BASE_V), .CNT_W(32)) u_ctl_regfile (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .exc_sum_set(exc_sum_set), .exc_mask_set(exc_mask_set),
    .int_id_in(int_id_in), .mm_stat_in(mm_stat_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault),
    .wr_fault(wr_fault), .op_strobe(op_strobe), .op_data(op_data)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [5:0]  idx;
    logic [63:0] wd;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{6'd3,  64'hdead_beef_cafe_f00d, 64'hdead_beef_cafe_f00d, 4'd3}, // R3
    '{6'd8,  64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, 4'd3}, // R3
    '{6'd9,  64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_000f, 4'd4}, // R4
    '{6'd10, 64'h0000_0000_0000_00a5, 64'h0000_0000_0000_0005, 4'd4}, // R4
    '{6'd11, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_001f, 4'd4}, // R4
    '{6'd12, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0018, 4'd5}, // R5
    '{6'd13, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_0018, 4'd5}, // R5
    '{6'd14, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0007_fff0, 4'd5}, // R5
    '{6'd15, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_003f, 4'd6}, // R6
    '{6'd16, 64'h0000_0000_0000_0055, 64'h0000_0000_0000_0015, 4'd6}, // R6
    '{6'd17, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_07f0, 4'd6}, // R6
    '{6'd18, 64'hffff_ffff_ffff_ffff, 64'hfe00_0000_0000_0000, 4'd6}, // R6
    '{6'd19, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_c000_0000, 4'd7}, // R7
    '{6'd20, 64'h1234_5678_9abc_def0, 64'h1234_5678_8000_0000, 4'd7}, // R7
    '{6'd22, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 4'd3}, // R3
    '{6'd0,  64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 4'd3}  // R3
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] i);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = i;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [63:0] c1;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid idle", 64'(rd_valid), 64'd0);
    chk("R1 wr_fault idle", 64'(wr_fault), 64'd0);
    chk("R1 op_strobe idle", 64'(op_strobe), 64'd0);
    do_read(6'd8);
    chk("R1 base reset", rd_data, BASE_V);
    chk("R2 rd_valid", 64'(rd_valid), 64'd1);
    do_read(6'd11);
    chk("R1 prio reset", rd_data, 64'd0);
    do_read(6'd3);
    chk("R1 scratch reset", rd_data, 64'd0);
    chk("R13 legal read no fault", 64'(rd_fault), 64'd0);

    // table walk: write, check fault, read back
    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k].idx, VEC[k].wd);
      chk($sformatf("R13 (R%0d vec %0d) wr_fault", VEC[k].req, k), 64'(wr_fault), 64'd0);
      do_read(VEC[k].idx);
      chk($sformatf("R%0d vec %0d data", VEC[k].req, k), rd_data, VEC[k].exp);
      chk($sformatf("R%0d vec %0d rd_fault", VEC[k].req, k), 64'(rd_fault), 64'd0);
    end

    // R2 read and write of the same index at one edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd5; wr_data = 64'h5555_aaaa_0000_1111;
    rd_en = 1'b1; rd_idx = 6'd5;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R2 read old value", rd_data, 64'd0);
    do_read(6'd5);
    chk("R2 read new value", rd_data, 64'h5555_aaaa_0000_1111);

    // R8 sticky set and clear on write
    @(negedge clk); exc_sum_set = 64'h30;
    @(negedge clk); exc_sum_set = 64'h01;
    @(negedge clk); exc_sum_set = 64'h00;
    do_read(6'd23);
    chk("R8 sticky accumulate", rd_data, 64'h31);
    do_write(6'd23, 64'hffff_ffff_ffff_ffff);
    chk("R8 clear write no fault", 64'(wr_fault), 64'd0);
    do_read(6'd23);
    chk("R8 cleared", rd_data, 64'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd23; wr_data = 64'h0; exc_sum_set = 64'h4;
    @(negedge clk);
    wr_en = 1'b0; exc_sum_set = 64'h0;
    do_read(6'd23);
    chk("R8 set survives clear", rd_data, 64'h4);
    @(negedge clk); exc_mask_set = 64'h2;
    @(negedge clk); exc_mask_set = 64'h0;
    do_read(6'd24);
    chk("R8 mask set", rd_data, 64'h2);
    do_write(6'd24, 64'h1234);
    do_read(6'd24);
    chk("R8 mask cleared", rd_data, 64'd0);

    // R9 read-only views
    int_id_in = 5'h13; mm_stat_in = 64'h0000_0abc_0000_0def;
    do_read(6'd25);
    chk("R9 int id view", rd_data, 64'h13);
    do_read(6'd26);
    chk("R9 mm stat view", rd_data, 64'h0000_0abc_0000_0def);
    do_write(6'd25, 64'hff);
    chk("R9 write int id faults", 64'(wr_fault), 64'd1);
    do_write(6'd26, 64'hff);
    chk("R9 write mm stat faults", 64'(wr_fault), 64'd1);
    do_read(6'd26);
    chk("R9 mm stat unaffected", rd_data, 64'h0000_0abc_0000_0def);

    // R10 command strobes
    do_write(6'd35, 64'h0bad_c0de_0000_0042);
    chk("R10 strobe bit 3", 64'(op_strobe), 64'h8);
    chk("R10 op data", op_data, 64'h0bad_c0de_0000_0042);
    chk("R10 no fault", 64'(wr_fault), 64'd0);
    @(negedge clk);
    chk("R10 strobe one cycle", 64'(op_strobe), 64'd0);
    do_write(6'd41, 64'h77);
    chk("R10 strobe bit 9", 64'(op_strobe), 64'h200);
    do_read(6'd35);
    chk("R10 read faults", 64'(rd_fault), 64'd1);
    chk("R10 read zero", rd_data, 64'd0);

    // R11 cycle register
    do_write(6'd21, 64'haaaa_5555_1234_5678);
    do_read(6'd21);
    c1 = rd_data;
    chk("R11 upper stored", {32'd0, c1[63:32]}, 64'h0000_0000_aaaa_5555);
    repeat (10) @(negedge clk);
    do_read(6'd21);
    chk("R11 live delta", 64'(rd_data[31:0] - c1[31:0]), 64'd12);

    // R12 unknown indices
    do_read(6'd27);
    chk("R12 read fault", 64'(rd_fault), 64'd1);
    chk("R12 read zero", rd_data, 64'd0);
    do_read(6'd63);
    chk("R12 read fault hi", 64'(rd_fault), 64'd1);
    do_write(6'd50, 64'h1);
    chk("R12 write fault", 64'(wr_fault), 64'd1);
    chk("R12 no strobe", 64'(op_strobe), 64'd0);
    do_write(6'd27, 64'hffff);
    chk("R12 write fault low", 64'(wr_fault), 64'd1);
    do_read(6'd27);
    chk("R12 still zero", rd_data, 64'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule